// File: doc/BRIEF.md
# Direct 8x8 DCT Multiply-Accumulate Array

This block computes the two-dimensional discrete cosine transform of an 8x8 block of 16-bit signed samples in one pass. It does not split the work into row and column passes. Sixty-four identical multiply-accumulate lanes run side by side, one for each output frequency bin (u,v). A controller outside the block presents all 64 samples on a wide input vector and steps a shared 6-bit sample index through the block. On every valid step, a single shared selector picks the indexed sample. Each lane multiplies that sample by its own fixed-point coefficient and adds the product to its accumulator. After the 64 steps, a latch strobe copies all 64 sums at once into the output vector.

Each lane holds a private 64-entry coefficient table, one entry per spatial position (i,j). Entry (i,j) of lane (u,v) is C(u)C(v)/4 · cos((2i+1)uπ/16) · cos((2j+1)vπ/16), where C(0)=1/√2 and C is 1 otherwise, scaled by 2^16. The table is built at elaboration from an 8-entry cosine table scaled by 2^15. Two entries are multiplied, and the product is rounded to an integer by a right shift of 16 with rounding half away from zero, symmetric in sign. Accumulators are 40 bits signed. A result is the accumulator shifted right arithmetically by 16, which is the floor of sum/2^16, kept to 24 bits signed. A start strobe clears every accumulator, so blocks can run back to back.

Top module: `dct2d_mac_array`

## Requirements
- R1: While rst is high at a rising edge, every accumulator and every result field is cleared to zero by that edge.
- R2: result_vec changes only on a rising edge where latch is high. At every other edge it keeps its value, even while accumulation goes on.
- R3: Accumulation never overflows. With all 64 samples at -32768, bin (0,0) reads exactly -262144. With all samples at 32767, it reads exactly 262136.
- R4: start high at an edge discards whatever the accumulators held. Each accumulator becomes the product for the current index if step_valid is also high, and zero otherwise.
- R5: At an edge where both start and step_valid are low, no accumulator changes, whatever step_idx and sample_vec carry.
- R6: The sample used on a step is sample_vec[step_idx*16 +: 16]. It sits at spatial row i = step_idx[5:3] and column j = step_idx[2:0].
- R7: Bin (u,v) appears at result_vec[(8u+v)*24 +: 24] as a signed value. After one valid step for each index 0..63, started with start and followed by latch, every bin lies within 2 of the real-valued DCT of the block for samples with magnitude up to 1024.
- R8: When latch and step_valid are high at the same edge, the latched results hold the sums from before that edge's product. The product is still added, and a later latch shows it.
- R9: For a block of 64 equal samples x, every bin other than (0,0) reads exactly 0 and bin (0,0) reads exactly 8x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears all accumulators at this edge (a product is loaded instead when step_valid is high) |
| step_valid | input | 1 | Adds one product per lane at this edge |
| step_idx | input | 6 | Shared sample index, row in bits 5:3, column in bits 2:0 |
| sample_vec | input | 1024 | 64 signed 16-bit samples, sample k at bits k*16 +: 16 |
| latch | input | 1 | Copies all 64 scaled sums into result_vec at this edge |
| result_vec | output | 1536 | 64 signed 24-bit bins, bin (u,v) at bits (8u+v)*24 +: 24 |

## Verification
An accumulator takes a step's product at the rising edge where the step is presented, so the last product of a block is in place one edge after index 63. The results then appear on result_vec at the next rising edge with latch high. The bench changes every input together at the falling edge and reads result_vec at the falling edge that follows the latch edge. It never samples at the edge that updates the results. For the hold and ignore cases it adds extra edges, with idle steps or with accumulation but no latch, and reads the outputs before the next latch, so any unwanted update would show at the ports.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 18;
    localparam int ACC_W    = 40;
    localparam int FRAC_W   = 16;
    localparam int RES_W    = 24;
    localparam int DIM      = 8;
    localparam int NPOS     = DIM * DIM;
    localparam int IDX_W    = $clog2(NPOS);
    localparam int PROD_W   = SAMPLE_W + COEF_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [PROD_W-1:0]   prod_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic signed [RES_W-1:0]    res_t;

    typedef struct packed {
        logic             start;
        logic             valid;
        logic             latch;
        logic [IDX_W-1:0] idx;
    } step_ctl_t;

    // Cosine of (m*pi/16) scaled by 2^15, for m in 0..8 (first quadrant and edge).
    function automatic int cos16_q15(int m);
        case (m)
            0: return 32768;
            1: return 32138;
            2: return 30274;
            3: return 27246;
            4: return 23170;
            5: return 18205;
            6: return 12540;
            7: return 6393;
            default: return 0;
        endcase
    endfunction

    // C(k)*cos((2*pos+1)*k*pi/16) scaled by 2^15.
    function automatic int trig_entry(int k, int pos);
        int m;
        bit neg;
        if (k == 0) return 23170;
        m = ((2 * pos + 1) * k) % 32;
        if (m > 16) m = 32 - m;
        neg = 1'b0;
        if (m > 8) begin
            m   = 16 - m;
            neg = 1'b1;
        end
        return neg ? -cos16_q15(m) : cos16_q15(m);
    endfunction

    // Shift right by FRAC_W with rounding half away from zero (sign symmetric).
    function automatic int sym_round_shift(longint p);
        longint half;
        half = longint'(1) <<< (FRAC_W - 1);
        if (p >= 0) return int'((p + half) >>> FRAC_W);
        return -int'(((-p) + half) >>> FRAC_W);
    endfunction

    // Full 64-entry coefficient table of lane (u,v), entry p at p*COEF_W.
    function automatic logic [NPOS*COEF_W-1:0] lane_table(int u, int v);
        logic [NPOS*COEF_W-1:0] t;
        int c;
        t = '0;
        for (int p = 0; p < NPOS; p++) begin
            c = sym_round_shift(longint'(trig_entry(u, p / DIM)) *
                                longint'(trig_entry(v, p % DIM)));
            t[p*COEF_W +: COEF_W] = COEF_W'(c);
        end
        return t;
    endfunction

endpackage

// File: rtl/dct_coef_rom.sv
module dct_coef_rom
    import dct_pkg::*;
#(
    parameter int U = 0,
    parameter int V = 0
) (
    input  logic [IDX_W-1:0] idx,
    output coef_t            coef
);
    localparam logic [NPOS*COEF_W-1:0] TABLE = lane_table(U, V);

    assign coef = TABLE[idx*COEF_W +: COEF_W];

endmodule

// File: rtl/dct_sample_sel.sv
module dct_sample_sel
    import dct_pkg::*;
(
    input  logic [NPOS*SAMPLE_W-1:0] vec,
    input  logic [IDX_W-1:0]         idx,
    output sample_t                  sample
);
    assign sample = vec[idx*SAMPLE_W +: SAMPLE_W];

endmodule

// File: rtl/dct_mac_lane.sv
module dct_mac_lane
    import dct_pkg::*;
#(
    parameter int U = 0,
    parameter int V = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  step_ctl_t ctl,
    input  sample_t   sample,
    output acc_t      acc_o,
    output res_t      res_o
);
    coef_t coef;
    prod_t prod;
    acc_t  acc;
    res_t  res;

    dct_coef_rom #(.U(U), .V(V)) u_rom (
        .idx  (ctl.idx),
        .coef (coef)
    );

    assign prod = sample * coef;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            res <= '0;
        end else begin
            if (ctl.start)
                acc <= ctl.valid ? ACC_W'(prod) : '0;
            else if (ctl.valid)
                acc <= acc + ACC_W'(prod);
            if (ctl.latch)
                res <= acc[FRAC_W +: RES_W];
        end
    end

    assign acc_o = acc;
    assign res_o = res;

endmodule

// File: rtl/dct2d_mac_array.sv
module dct2d_mac_array
    import dct_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    step_valid,
    input  logic [IDX_W-1:0]        step_idx,
    input  logic [NPOS*SAMPLE_W-1:0] sample_vec,
    input  logic                    latch,
    output logic [NPOS*RES_W-1:0]   result_vec
);
    step_ctl_t               ctl;
    sample_t                 cur_sample;
    logic [NPOS*ACC_W-1:0]   acc_all;

    assign ctl = '{start: start, valid: step_valid, latch: latch, idx: step_idx};

    dct_sample_sel u_sel (
        .vec    (sample_vec),
        .idx    (step_idx),
        .sample (cur_sample)
    );

    for (genvar gu = 0; gu < DIM; gu++) begin : g_u
        for (genvar gv = 0; gv < DIM; gv++) begin : g_v
            localparam int K = gu * DIM + gv;
            dct_mac_lane #(.U(gu), .V(gv)) u_lane (
                .clk    (clk),
                .rst    (rst),
                .ctl    (ctl),
                .sample (cur_sample),
                .acc_o  (acc_all[K*ACC_W +: ACC_W]),
                .res_o  (result_vec[K*RES_W +: RES_W])
            );
        end
    end

endmodule

// File: rtl/dct2d_mac_chk.sv
module dct2d_mac_chk
    import dct_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  step_valid,
    input logic                  latch,
    input logic [NPOS*RES_W-1:0] result_vec,
    input logic [NPOS*ACC_W-1:0] acc_all
);
    localparam longint BOUND = longint'(NPOS) * (longint'(1) <<< (SAMPLE_W - 1))
                               * (longint'(1) <<< (FRAC_W - 2));

    // R1: reset clears results and sums
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (result_vec == '0 && acc_all == '0));

    // R2: outputs hold without latch
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(result_vec));

    // R4: start without a step empties every accumulator
    assert_start_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !step_valid) |=> acc_all == '0);

    // R5: idle edges leave accumulators untouched
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!start && !step_valid) |=> $stable(acc_all));

    for (genvar k = 0; k < NPOS; k++) begin : g_ovf
        // R3: every accumulator stays inside the reachable range
        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
            ($signed(acc_all[k*ACC_W +: ACC_W]) <= BOUND &&
             $signed(acc_all[k*ACC_W +: ACC_W]) >= -BOUND));
    end

endmodule

bind dct2d_mac_array dct2d_mac_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .step_valid (step_valid),
    .latch      (latch),
    .result_vec (result_vec),
    .acc_all    (acc_all)
);

// File: tb/sim_dct2d_mac_array.sv
module sim_dct2d_mac_array;
    import dct_pkg::*;

    localparam int  CLK_PERIOD = 10;
    localparam real PI = 3.14159265358979;
    localparam real TOL = 2.0;

    // stimulus table: kind 0 random, 2 checkerboard, 3 impulse at SEED, 4 ramp
    localparam int NT = 6;
    localparam int T_KIND [NT] = '{0, 0, 2, 3, 4, 0};
    localparam int T_AMP  [NT] = '{1024, 512, 1000, 1024, 1024, 1};
    localparam int T_SEED [NT] = '{7, 99, 0, 13, 0, 5};

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     start = 1'b0;
    logic                     step_valid = 1'b0;
    logic [IDX_W-1:0]         step_idx = '0;
    logic [NPOS*SAMPLE_W-1:0] sample_vec = '0;
    logic                     latch = 1'b0;
    logic [NPOS*RES_W-1:0]    result_vec;

    int          total = 0;
    int          bad = 0;
    int          smp [NPOS];
    int unsigned lcg = 1;
    bit          finished = 1'b0;

    dct2d_mac_array u0 (
        .clk(clk), .rst(rst), .start(start), .step_valid(step_valid),
        .step_idx(step_idx), .sample_vec(sample_vec), .latch(latch),
        .result_vec(result_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int rnd(int amp);
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'((lcg >> 16) % (2 * amp + 1)) - amp;
    endfunction

    function automatic logic [NPOS*SAMPLE_W-1:0] pack_smp();
        logic [NPOS*SAMPLE_W-1:0] v;
        for (int p = 0; p < NPOS; p++) v[p*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(smp[p]);
        return v;
    endfunction

    function automatic real ref_dct(int u, int v);
        real s, cu, cv;
        s = 0.0;
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++)
                s += real'(smp[i*DIM + j]) * $cos((2*i + 1) * u * PI / 16.0)
                                         * $cos((2*j + 1) * v * PI / 16.0);
        cu = (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
        cv = (v == 0) ? 1.0 / $sqrt(2.0) : 1.0;
        return s * cu * cv / 4.0;
    endfunction

    function automatic int lane_out(int k);
        return int'($signed(result_vec[k*RES_W +: RES_W]));
    endfunction

    task automatic fill(int kind, int amp, int seed);
        lcg = seed;
        for (int p = 0; p < NPOS; p++) begin
            case (kind)
                0: smp[p] = rnd(amp);
                1: smp[p] = amp;
                2: smp[p] = (((p / DIM) + (p % DIM)) % 2 == 1) ? amp : -amp;
                3: smp[p] = (p == seed) ? amp : 0;
                default: smp[p] = p * 16 - 512;
            endcase
        end
    endtask

    task automatic drive(bit st, bit vl, bit lt, int idx, logic [NPOS*SAMPLE_W-1:0] vec);
        @(negedge clk);
        start      = st;
        step_valid = vl;
        latch      = lt;
        step_idx   = IDX_W'(idx);
        sample_vec = vec;
    endtask

    task automatic feed_block();
        for (int k = 0; k < NPOS; k++) drive(k == 0, 1'b1, 1'b0, k, pack_smp());
    endtask

    task automatic latch_and_settle();
        drive(1'b0, 1'b0, 1'b1, 0, pack_smp());
        drive(1'b0, 1'b0, 1'b0, 0, pack_smp());
    endtask

    task automatic check_int(string tag, int k, int exp);
        total++;
        if (lane_out(k) != exp) begin
            bad++;
            $display("FAIL %s lane %0d: actual %0d expected %0d", tag, k, lane_out(k), exp);
        end
    endtask

    task automatic check_ref_all(string tag);
        real e, d;
        for (int u = 0; u < DIM; u++)
            for (int v = 0; v < DIM; v++) begin
                e = ref_dct(u, v);
                d = real'(lane_out(u*DIM + v)) - e;
                total++;
                if (d > TOL || d < -TOL) begin
                    bad++;
                    $display("FAIL %s lane %0d: actual %0d expected %0f", tag,
                             u*DIM + v, lane_out(u*DIM + v), e);
                end
            end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int keep;
        int prev0, prev63;
        logic [NPOS*SAMPLE_W-1:0] junk;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        for (int k = 0; k < NPOS; k++) check_int("R1 reset", k, 0);

        // R7 / R6: table-driven blocks against the real-valued transform
        for (int t = 0; t < NT; t++) begin
            fill(T_KIND[t], T_AMP[t], T_SEED[t]);
            feed_block();
            latch_and_settle();
            check_ref_all(T_KIND[t] == 3 ? "R6 impulse" : "R7 block");
        end

        // R3 / R9: full-scale constants
        fill(1, -32768, 0);
        feed_block();
        latch_and_settle();
        check_int("R3 dc min", 0, -262144);
        for (int k = 1; k < NPOS; k++) check_int("R9 ac zero", k, 0);
        fill(1, 32767, 0);
        feed_block();
        latch_and_settle();
        check_int("R3 dc max", 0, 262136);
        for (int k = 1; k < NPOS; k++) check_int("R9 ac zero", k, 0);
        fill(1, -300, 0);
        feed_block();
        latch_and_settle();
        check_int("R9 dc 8x", 0, -2400);
        check_int("R9 ac zero", 27, 0);

        // R2: accumulate a fresh block without latch, outputs must hold
        prev0  = lane_out(0);
        prev63 = lane_out(63);
        fill(0, 1024, 321);
        feed_block();
        drive(1'b0, 1'b0, 1'b0, 0, pack_smp());
        check_int("R2 hold", 0, prev0);
        check_int("R2 hold", 63, prev63);

        // R4: stale partial sums, then a started impulse block
        for (int k = 0; k < 20; k++) drive(1'b0, 1'b1, 1'b0, k, {NPOS{16'sh7fff}});
        fill(3, 1024, 9);
        feed_block();
        latch_and_settle();
        check_ref_all("R4 start clears");

        // R5: idle steps with junk index and samples interleaved
        fill(0, 1024, 77);
        junk = {NPOS{16'sh7abc}};
        for (int k = 0; k < NPOS; k++) begin
            drive(k == 0, 1'b1, 1'b0, k, pack_smp());
            if (k % 8 == 3) drive(1'b0, 1'b0, 1'b0, 63 - k, junk);
        end
        drive(1'b0, 1'b0, 1'b0, 5, junk);
        latch_and_settle();
        check_ref_all("R5 idle ignored");

        // R8: latch and step in one edge
        fill(0, 1024, 4242);
        feed_block();
        keep   = smp[0];
        smp[0] = 1024;
        drive(1'b0, 1'b1, 1'b1, 0, pack_smp());
        smp[0] = keep;
        drive(1'b0, 1'b0, 1'b0, 0, pack_smp());
        check_ref_all("R8 latch before add");
        smp[0] = keep + 1024;
        latch_and_settle();
        check_ref_all("R8 add kept");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule